// File: doc/BRIEF.md
# Selectable-Precision Taint-Tracking Logic Unit

This block is a bitwise logic unit. Each data bit carries a shadow taint bit that marks whether the bit depends on untrusted input. Every bit slice computes AND, OR or XOR of its two operand bits and registers the result. Next to each slice sits a taint gate that computes the taint of the result bit. A 3-bit select field per bit picks the rule that gate uses. The rules range from exact tracking, through partly exact and fully conservative forms, to fixed constants. A designer can therefore trade tracking precision against logic bit by bit, or pin chosen bits to a known taint value.

A fourth opcode clears the result to a constant zero. The taint of that constant comes from a policy input, so constants can be marked as clean or as tainted. The data result and the taint vector are always exported together. Both come from one output register stage, so results appear one clock after the inputs.

Top module: `tt_datapath`

## Requirements
- R1: Opcode codes are 0 = AND, 1 = OR, 2 = XOR (bitwise on `a_i`, `b_i`) and 3 = clear (result all zero). `y_o` shows the result one clock edge after the inputs are sampled.
- R2: With rule code 0 (precise) in a bit's select field, the taint bit is 1 exactly when some change to the tainted input bits of that slice would change its result bit. For AND this is (a&bt)|(b&at)|(at&bt). For OR it is (~a&bt)|(~b&at)|(at&bt). For XOR it is at|bt.
- R3: Rule code 1 gives at|(p&bt) and rule code 2 gives bt|(q&at). For AND, p=a and q=b. For OR, p=~a and q=~b. For XOR both rules give at|bt.
- R4: Rule code 3 (conservative) gives at|bt for every gate opcode.
- R5: Rule code 4 gives at alone, and rule code 5 gives bt alone.
- R6: Rule code 6 forces the taint bit to 1, and rule code 7 forces it to 0.
- R7: When a slice has at=bt=0 and rule code 0, its taint bit is 0 for every gate opcode.
- R8: Rule codes 0, 1, 2, 3 and 6 never report less taint than the precise rule for the same inputs.
- R9: Under opcode 3, every taint bit equals `const_taint_i` and the select fields are ignored.
- R10: While `rst_n` is low, `y_o` and `y_taint_o` are 0.
- R11: Bit i is controlled by select bits [3i+2:3i], and that field affects no other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Opcode: 0 AND, 1 OR, 2 XOR, 3 clear |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| a_taint_i | input | WIDTH | Taint of operand A |
| b_taint_i | input | WIDTH | Taint of operand B |
| rule_sel_i | input | 3*WIDTH | Per-bit rule select fields |
| const_taint_i | input | 1 | Taint given to constant results |
| y_o | output | WIDTH | Registered result |
| y_taint_o | output | WIDTH | Registered result taint |

## Verification
The block holds no state beyond its output register. A fault in a rule candidate or in the select decode therefore shows as a wrong taint bit on the very next clock, but only in the bit whose field selects that candidate. The bench checks the precise rule against a model that flips every tainted input bit. It then drives each rule code across whole vectors, and uses mixed select patterns to catch a field steering the wrong bit. The soundness check pairs each reduced rule with a precise run on the same inputs, so a rule that silently drops taint is exposed.

// File: rtl/tt_pkg.sv
package tt_pkg;

    typedef enum logic [1:0] {
        OP_AND = 2'd0,
        OP_OR  = 2'd1,
        OP_XOR = 2'd2,
        OP_CLR = 2'd3
    } tt_op_e;

    typedef enum logic [2:0] {
        RULE_PRECISE  = 3'd0,
        RULE_A_BIASED = 3'd1,
        RULE_B_BIASED = 3'd2,
        RULE_CONSERV  = 3'd3,
        RULE_A_ONLY   = 3'd4,
        RULE_B_ONLY   = 3'd5,
        RULE_ONE      = 3'd6,
        RULE_ZERO     = 3'd7
    } tt_rule_e;

    localparam int unsigned RULE_W     = 3;
    localparam int unsigned RULE_COUNT = 1 << RULE_W;

endpackage

// File: rtl/tt_rule_bank.sv
module tt_rule_bank
    import tt_pkg::*;
(
    input  tt_op_e                  op,
    input  logic                    a,
    input  logic                    b,
    input  logic                    at,
    input  logic                    bt,
    input  logic                    const_taint,
    output logic [RULE_COUNT-1:0]   cand
);
    logic pass_a;
    logic pass_b;
    logic both;

    // pass_a: b's value lets a change reach the output (and likewise)
    always_comb begin
        pass_a = 1'b1;
        pass_b = 1'b1;
        unique case (op)
            OP_AND: begin
                pass_a = b;
                pass_b = a;
            end
            OP_OR: begin
                pass_a = ~b;
                pass_b = ~a;
            end
            OP_XOR: begin
                pass_a = 1'b1;
                pass_b = 1'b1;
            end
            OP_CLR: begin
                pass_a = 1'b0;
                pass_b = 1'b0;
            end
        endcase
    end

    assign both = at & bt;

    always_comb begin
        if (op == OP_CLR) begin
            cand = {RULE_COUNT{const_taint}};
        end else begin
            cand[RULE_PRECISE]  = (pass_b & bt) | (pass_a & at) | both;
            cand[RULE_A_BIASED] = at | (pass_b & bt);
            cand[RULE_B_BIASED] = bt | (pass_a & at);
            cand[RULE_CONSERV]  = at | bt;
            cand[RULE_A_ONLY]   = at;
            cand[RULE_B_ONLY]   = bt;
            cand[RULE_ONE]      = 1'b1;
            cand[RULE_ZERO]     = 1'b0;
        end
    end
endmodule

// File: rtl/tt_rule_mux.sv
module tt_rule_mux
    import tt_pkg::*;
(
    input  logic [RULE_COUNT-1:0] cand,
    input  logic [RULE_W-1:0]     sel,
    output logic                  taint
);
    always_comb begin
        taint = 1'b0;
        for (int k = 0; k < RULE_COUNT; k++) begin
            if (sel == RULE_W'(k)) taint = cand[k];
        end
    end
endmodule

// File: rtl/tt_bit_slice.sv
module tt_bit_slice
    import tt_pkg::*;
(
    input  tt_op_e              op,
    input  logic                a,
    input  logic                b,
    input  logic                at,
    input  logic                bt,
    input  logic [RULE_W-1:0]   sel,
    input  logic                const_taint,
    output logic                y,
    output logic                yt
);
    logic [RULE_COUNT-1:0] cand;

    always_comb begin
        unique case (op)
            OP_AND: y = a & b;
            OP_OR:  y = a | b;
            OP_XOR: y = a ^ b;
            OP_CLR: y = 1'b0;
        endcase
    end

    tt_rule_bank u_bank (
        .op          (op),
        .a           (a),
        .b           (b),
        .at          (at),
        .bt          (bt),
        .const_taint (const_taint),
        .cand        (cand)
    );

    tt_rule_mux u_mux (
        .cand  (cand),
        .sel   (sel),
        .taint (yt)
    );
endmodule

// File: rtl/tt_datapath.sv
module tt_datapath
    import tt_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              op_i,
    input  logic [WIDTH-1:0]        a_i,
    input  logic [WIDTH-1:0]        b_i,
    input  logic [WIDTH-1:0]        a_taint_i,
    input  logic [WIDTH-1:0]        b_taint_i,
    input  logic [RULE_W*WIDTH-1:0] rule_sel_i,
    input  logic                    const_taint_i,
    output logic [WIDTH-1:0]        y_o,
    output logic [WIDTH-1:0]        y_taint_o
);
    localparam int unsigned SEL_W = RULE_W * WIDTH;

    tt_op_e             op;
    logic [WIDTH-1:0]   y_d;
    logic [WIDTH-1:0]   yt_d;
    logic [SEL_W-1:0]   sel_flat;

    assign op       = tt_op_e'(op_i);
    assign sel_flat = rule_sel_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        tt_bit_slice u_slice (
            .op          (op),
            .a           (a_i[i]),
            .b           (b_i[i]),
            .at          (a_taint_i[i]),
            .bt          (b_taint_i[i]),
            .sel         (sel_flat[RULE_W*i +: RULE_W]),
            .const_taint (const_taint_i),
            .y           (y_d[i]),
            .yt          (yt_d[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_o       <= '0;
            y_taint_o <= '0;
        end else begin
            y_o       <= y_d;
            y_taint_o <= yt_d;
        end
    end
endmodule

// File: rtl/tt_datapath_chk.sv
module tt_datapath_chk
    import tt_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              op_i,
    input  logic [WIDTH-1:0]        a_i,
    input  logic [WIDTH-1:0]        b_i,
    input  logic [WIDTH-1:0]        a_taint_i,
    input  logic [WIDTH-1:0]        b_taint_i,
    input  logic [RULE_W*WIDTH-1:0] rule_sel_i,
    input  logic                    const_taint_i,
    input  logic [WIDTH-1:0]        y_o,
    input  logic [WIDTH-1:0]        y_taint_o
);
    AST_CLR_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_CLR) |-> (y_taint_o == {WIDTH{$past(const_taint_i)}} && y_o == '0)); // R9

    AST_AND_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_AND) |-> (y_o == ($past(a_i) & $past(b_i)))); // R1

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        AST_ZERO_RULE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_i) != OP_CLR && $past(rule_sel_i[RULE_W*i +: RULE_W]) == RULE_ZERO)
            |-> !y_taint_o[i]); // R6

        AST_ONE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_i) != OP_CLR && $past(rule_sel_i[RULE_W*i +: RULE_W]) == RULE_ONE)
            |-> y_taint_o[i]); // R6

        AST_CONSERV_RULE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_i) != OP_CLR && $past(rule_sel_i[RULE_W*i +: RULE_W]) == RULE_CONSERV)
            |-> (y_taint_o[i] == ($past(a_taint_i[i]) | $past(b_taint_i[i])))); // R4

        AST_CLEAN_PRECISE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_i) != OP_CLR && $past(rule_sel_i[RULE_W*i +: RULE_W]) == RULE_PRECISE
             && !$past(a_taint_i[i]) && !$past(b_taint_i[i]))
            |-> !y_taint_o[i]); // R7
    end
endmodule

bind tt_datapath tt_datapath_chk #(.WIDTH(WIDTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_i          (op_i),
    .a_i           (a_i),
    .b_i           (b_i),
    .a_taint_i     (a_taint_i),
    .b_taint_i     (b_taint_i),
    .rule_sel_i    (rule_sel_i),
    .const_taint_i (const_taint_i),
    .y_o           (y_o),
    .y_taint_o     (y_taint_o)
);

// File: tb/sim_tt_datapath.sv
module sim_tt_datapath;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int SW = 3 * W;
    localparam int NV = 15;

    // op[74:73] a[72:65] b[64:57] at[56:49] bt[48:41] sel[40:17] ct[16] y[15:8] yt[7:0]
    localparam logic [74:0] VEC [NV] = '{
        {2'd0, 8'hF0, 8'hCC, 8'h00, 8'h00, 24'h000000, 1'b0, 8'hC0, 8'h00},
        {2'd1, 8'hF0, 8'h0C, 8'h0F, 8'h00, 24'h000000, 1'b0, 8'hFC, 8'h03},
        {2'd0, 8'hFF, 8'h00, 8'h00, 8'hFF, 24'h000000, 1'b0, 8'h00, 8'hFF},
        {2'd2, 8'hAA, 8'h55, 8'h01, 8'h80, 24'h000000, 1'b0, 8'hFF, 8'h81},
        {2'd0, 8'h00, 8'h00, 8'hFF, 8'h00, 24'h000000, 1'b0, 8'h00, 8'h00},
        {2'd3, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 24'h000000, 1'b0, 8'h00, 8'h00},
        {2'd3, 8'hFF, 8'hFF, 8'h00, 8'h00, 24'hFFFFFF, 1'b1, 8'h00, 8'hFF},
        {2'd0, 8'h00, 8'h00, 8'h0F, 8'hF0, 24'h6DB6DB, 1'b0, 8'h00, 8'hFF},
        {2'd0, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 24'hFFFFFF, 1'b0, 8'hFF, 8'h00},
        {2'd1, 8'h00, 8'h00, 8'h00, 8'h00, 24'hDB6DB6, 1'b0, 8'h00, 8'hFF},
        {2'd0, 8'hFF, 8'hFF, 8'h3C, 8'hC3, 24'h924924, 1'b0, 8'hFF, 8'h3C},
        {2'd0, 8'hFF, 8'hFF, 8'h3C, 8'hC3, 24'hB6DB6D, 1'b0, 8'hFF, 8'hC3},
        {2'd0, 8'h0F, 8'hFF, 8'h00, 8'hFF, 24'h249249, 1'b0, 8'h0F, 8'h0F},
        {2'd1, 8'h00, 8'hF0, 8'hFF, 8'h00, 24'h492492, 1'b0, 8'hF0, 8'h0F},
        {2'd0, 8'hFF, 8'hFF, 8'hFF, 8'h00, 24'h000007, 1'b0, 8'hFF, 8'hFE}
    };
    localparam string VEC_REQ [NV] = '{"R1", "R2", "R2", "R2", "R7", "R9", "R9",
                                       "R4", "R6", "R6", "R5", "R5", "R3", "R3", "R11"};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    op_i = '0;
    logic [W-1:0]  a_i = '0, b_i = '0, a_taint_i = '0, b_taint_i = '0;
    logic [SW-1:0] rule_sel_i = '0;
    logic          const_taint_i = 1'b0;
    logic [W-1:0]  y_o, y_taint_o;
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tt_datapath #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .a_taint_i(a_taint_i), .b_taint_i(b_taint_i), .rule_sel_i(rule_sel_i),
        .const_taint_i(const_taint_i), .y_o(y_o), .y_taint_o(y_taint_o)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] at, input logic [W-1:0] bt,
                         input logic [SW-1:0] sel, input logic ct);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; a_taint_i = at; b_taint_i = bt;
        rule_sel_i = sel; const_taint_i = ct;
        @(posedge clk);
        #1;
    endtask

    function automatic logic gate(input logic [1:0] op, input logic a, input logic b);
        case (op)
            2'd0: gate = a & b;
            2'd1: gate = a | b;
            2'd2: gate = a ^ b;
            default: gate = 1'b0;
        endcase
    endfunction

    // precise reference: flip every tainted input bit and look for a change
    function automatic logic [W-1:0] flip_ref(input logic [1:0] op, input logic [W-1:0] a,
                                              input logic [W-1:0] b, input logic [W-1:0] at,
                                              input logic [W-1:0] bt);
        logic [W-1:0] r = '0;
        for (int i = 0; i < W; i++) begin
            for (int fa = 0; fa < 2; fa++) begin
                for (int fb = 0; fb < 2; fb++) begin
                    if ((fa == 0 || at[i]) && (fb == 0 || bt[i]) &&
                        gate(op, a[i] ^ fa[0], b[i] ^ fb[0]) != gate(op, a[i], b[i]))
                        r[i] = 1'b1;
                end
            end
        end
        return r;
    endfunction

    function automatic logic rule_ref(input logic [1:0] op, input logic a, input logic b,
                                      input logic at, input logic bt, input logic [2:0] rule);
        logic p = (op == 2'd0) ? a : (op == 2'd1) ? ~a : 1'b1;
        logic q = (op == 2'd0) ? b : (op == 2'd1) ? ~b : 1'b1;
        case (rule)
            3'd1: rule_ref = (op == 2'd2) ? (at | bt) : (at | (p & bt));
            3'd2: rule_ref = (op == 2'd2) ? (at | bt) : (bt | (q & at));
            3'd3: rule_ref = at | bt;
            3'd4: rule_ref = at;
            3'd5: rule_ref = bt;
            3'd6: rule_ref = 1'b1;
            3'd7: rule_ref = 1'b0;
            default: rule_ref = 1'bx;
        endcase
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        check("R10", y_o, '0);
        check("R10", y_taint_o, '0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][74:73], VEC[v][72:65], VEC[v][64:57], VEC[v][56:49],
                  VEC[v][48:41], VEC[v][40:17], VEC[v][16]);
            check(VEC_REQ[v], y_o, VEC[v][15:8]);
            check(VEC_REQ[v], y_taint_o, VEC[v][7:0]);
        end

        // R11: alternate fields ONE / ZERO, must land on alternate bits
        apply(2'd0, 8'h00, 8'h00, 8'h00, 8'h00, {4{3'd7, 3'd6}}, 1'b0);
        check("R11", y_taint_o, 8'h55);

        // R9: select ignored under clear, policy clean
        apply(2'd3, 8'hA5, 8'h5A, 8'hFF, 8'hFF, {8{3'd6}}, 1'b0);
        check("R9", y_taint_o, 8'h00);

        for (int n = 0; n < 300; n++) begin
            logic [1:0]    op = 2'($urandom_range(2));
            logic [W-1:0]  a  = W'($urandom);
            logic [W-1:0]  b  = W'($urandom);
            logic [W-1:0]  at = W'($urandom);
            logic [W-1:0]  bt = W'($urandom);
            logic [SW-1:0] sel = SW'($urandom);
            logic [W-1:0]  prec;
            logic [W-1:0]  exp_r = '0;
            logic [W-1:0]  sound = '0;
            logic [W-1:0]  exp_y = '0;
            for (int i = 0; i < W; i++) exp_y[i] = gate(op, a[i], b[i]);
            apply(op, a, b, at, bt, '0, 1'b0);
            prec = y_taint_o;
            check("R1", y_o, exp_y);
            check("R2", prec, flip_ref(op, a, b, at, bt));
            check("R7", prec & ~(at | bt), '0);
            for (int i = 0; i < W; i++) begin
                if (sel[3*i +: 3] == 3'd0) sel[3*i +: 3] = 3'd3;
                exp_r[i] = rule_ref(op, a[i], b[i], at[i], bt[i], sel[3*i +: 3]);
                sound[i] = (sel[3*i +: 3] <= 3'd3 || sel[3*i +: 3] == 3'd6);
            end
            apply(op, a, b, at, bt, sel, 1'b0);
            check("R3 R5 R6", y_taint_o, exp_r);
            check("R8", prec & sound & ~y_taint_o, '0);
        end

        // R10: asynchronous reset mid-run
        apply(2'd1, 8'hFF, 8'h00, 8'hFF, 8'hFF, {8{3'd6}}, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10", y_o, '0);
        check("R10", y_taint_o, '0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule